// File: doc/BRIEF.md
# Posted-Write Buffer with Address-Match Forwarding

This block holds writes that have been accepted from a request agent but not yet sent to the DRAM scheduler. A sender may present a write only while it holds a credit. There is one credit for each free slot. Every accepted write is reported back as posted in the following cycle, well before it reaches memory. Every incoming write and read is matched by address against all occupied slots in the same cycle.

A read that matches is answered from the buffer with a one-cycle response. A write that matches is folded into the slot it matched. A full write replaces the slot's data, and a partial write changes only the byte lanes it enables. A write that matches nothing takes a new slot at the tail. The DRAM side always sees the oldest occupied slot. That slot is freed on the handshake.

Credits come back on a two-bit return count. Each freed slot returns one credit, and each merged write returns the credit it spent. Occupancy, a running count of posted writes and one-cycle hit pulses feed a monitoring counter.

Top module: `wpq_top`

## Requirements
- R1: While reset is held and after it is released, the buffer is empty: occupancy 0, `iss_valid` 0, `wr_posted`, `credit_ret`, `rd_resp_valid`, both hit pulses and `posted_cnt` all 0.
- R2: Every write presented on `wr_valid` raises `wr_posted` in the next cycle and adds one to `posted_cnt`, which wraps at its width.
- R3: A write whose address matches no occupied slot takes a new slot. Its data is stored with the disabled byte lanes cleared, and its lane enables are kept. Occupancy rises by one, up to the depth (32 by default).
- R4: A write with all lanes enabled that matches an occupied slot replaces that slot's data and takes no new slot.
- R5: A partial write that matches an occupied slot replaces only its enabled byte lanes. Lane b is bits 8b+7..8b of the data and bit b of `wr_be`. The slot's lane enables become the OR of the old and new enables.
- R6: A read presented on `rd_valid` gives `rd_resp_valid` in the next cycle. On a match, `rd_resp_hit` is 1 and `rd_resp_data` is the slot's data. On no match, `rd_resp_hit` is 0 and `rd_resp_data` is 0.
- R7: When occupied, the issue port shows the oldest occupied slot's address, data and lane enables. A cycle with `iss_valid` and `iss_ready` both high frees that slot.
- R8: In a cycle where an incoming write matches the oldest slot, `iss_valid` is 0.
- R9: `credit_ret` in a cycle equals the number of slots issued plus the number of writes merged in the previous cycle (0, 1 or 2).
- R10: `wr_hit_pulse` and `rd_hit_pulse` are high for exactly one cycle after each merged write and each read hit.
- R11: A read and a write in the same cycle to the same address: the read sees the buffer as it was before that write.
- R12: At most one occupied slot holds any given address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write presented (sender holds a credit) |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8*BYTES | Write data |
| wr_be | input | BYTES | Write byte-lane enables |
| wr_posted | output | 1 | Write of the previous cycle is posted |
| credit_ret | output | 2 | Credits returned this cycle |
| rd_valid | input | 1 | Read lookup presented |
| rd_addr | input | ADDR_W | Read address |
| rd_resp_valid | output | 1 | Read lookup result valid |
| rd_resp_hit | output | 1 | Read matched a pending write |
| rd_resp_data | output | 8*BYTES | Forwarded data on a hit, else 0 |
| iss_valid | output | 1 | Oldest slot offered to DRAM |
| iss_ready | input | 1 | DRAM side accepts the offered slot |
| iss_addr | output | ADDR_W | Address of offered slot |
| iss_data | output | 8*BYTES | Data of offered slot |
| iss_be | output | BYTES | Lane enables of offered slot |
| occupancy | output | $clog2(DEPTH)+1 | Occupied slots |
| posted_cnt | output | CNT_W | Running count of posted writes |
| rd_hit_pulse | output | 1 | One-cycle read-hit event |
| wr_hit_pulse | output | 1 | One-cycle write-merge event |

## Verification
A directed fill with distinct addresses and the issue port stalled checks allocation, the full-depth occupancy and credit exhaustion. Later writes to those addresses separate full replacement from a lane-wise merge. A write aimed at the oldest slot while the scheduler is ready shows the issue being held back. A read and a write to the same address in the same cycle show whether the lookup sees state from before or after that write. A long random run over only eight addresses, with random lane enables and a random ready signal, is compared every cycle against a queue-based model. That run mixes merges, forwarding, issue and credit returns in every combination that can occur together.

// File: rtl/wpq_pkg.sv
// Shared defaults and the per-cycle write disposition for the posted-write buffer.
package wpq_pkg;
    localparam int DEF_DEPTH  = 32;
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_BYTES  = 8;
    localparam int DEF_CNT_W  = 16;

    // What the buffer does with the write presented this cycle.
    typedef enum logic [1:0] {
        WD_NONE  = 2'd0,
        WD_MERGE = 2'd1,
        WD_ALLOC = 2'd2
    } wr_disp_e;
endpackage

// File: rtl/wpq_cam.sv
// Address lookup across all slots.
// Produces the per-slot match vector, a hit flag and the encoded index of the match.
// Assumes at most one occupied slot per address, so the encoder needs no priority.
module wpq_cam #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             valid_vec,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr_vec,
    input  logic [ADDR_W-1:0]            key,
    output logic [DEPTH-1:0]             match,
    output logic                         hit,
    output logic [IDX_W-1:0]             idx
);
    // One comparator per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid_vec[g] && (addr_vec[g] == key);
    end

    // OR-encode the match into an index and a hit flag.
    always_comb begin
        idx = '0;
        for (int i = 0; i < DEPTH; i++)
            if (match[i]) idx = idx | IDX_W'(i);
        hit = |match;
    end
endmodule

// File: rtl/wpq_store.sv
// Slot storage: valid bit, address, data and lane enables for each slot.
// Allocation writes a whole slot with disabled lanes cleared. Merge updates the enabled lanes.
// Free clears the valid bit.
// Assumes the controller never allocates, merges and frees the same slot in one cycle.
module wpq_store #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 16,
    parameter int BYTES  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int DW    = 8 * BYTES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_en,
    input  logic [IDX_W-1:0]             alloc_idx,
    input  logic                         merge_en,
    input  logic [IDX_W-1:0]             merge_idx,
    input  logic                         free_en,
    input  logic [IDX_W-1:0]             free_idx,
    input  logic [ADDR_W-1:0]            in_addr,
    input  logic [DW-1:0]                in_data,
    input  logic [BYTES-1:0]             in_be,
    output logic [DEPTH-1:0]             valid_vec,
    output logic [DEPTH-1:0][ADDR_W-1:0] addr_vec,
    output logic [DEPTH-1:0][DW-1:0]     data_vec,
    output logic [DEPTH-1:0][BYTES-1:0]  be_vec
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Per-slot update: reset, free, allocate or merge lanes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
                addr_vec[g]  <= '0;
                data_vec[g]  <= '0;
                be_vec[g]    <= '0;
            end else begin
                if (free_en && free_idx == IDX_W'(g))
                    valid_vec[g] <= 1'b0;
                if (alloc_en && alloc_idx == IDX_W'(g)) begin
                    valid_vec[g] <= 1'b1;
                    addr_vec[g]  <= in_addr;
                    be_vec[g]    <= in_be;
                    for (int b = 0; b < BYTES; b++)
                        data_vec[g][8*b +: 8] <= in_be[b] ? in_data[8*b +: 8] : 8'h00;
                end
                if (merge_en && merge_idx == IDX_W'(g)) begin
                    be_vec[g] <= be_vec[g] | in_be;
                    for (int b = 0; b < BYTES; b++)
                        if (in_be[b]) data_vec[g][8*b +: 8] <= in_data[8*b +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/wpq_top.sv
// Posted-write buffer with address-match forwarding.
// Slots are filled in ring order, so the oldest occupied slot is always at the head pointer.
// A merge leaves a slot where it is.
// Assumes DEPTH is a power of two and that the sender presents a write only while it holds a credit.
module wpq_top
    import wpq_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BYTES  = DEF_BYTES,
    parameter int CNT_W  = DEF_CNT_W,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int OCC_W = IDX_W + 1,
    localparam int DW    = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [BYTES-1:0]  wr_be,
    output logic              wr_posted,
    output logic [1:0]        credit_ret,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_resp_valid,
    output logic              rd_resp_hit,
    output logic [DW-1:0]     rd_resp_data,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [DW-1:0]     iss_data,
    output logic [BYTES-1:0]  iss_be,
    output logic [OCC_W-1:0]  occupancy,
    output logic [CNT_W-1:0]  posted_cnt,
    output logic              rd_hit_pulse,
    output logic              wr_hit_pulse
);
    logic [DEPTH-1:0]             valid_vec;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_vec;
    logic [DEPTH-1:0][DW-1:0]     data_vec;
    logic [DEPTH-1:0][BYTES-1:0]  be_vec;
    logic [DEPTH-1:0]             w_match, r_match;
    logic                         w_hit, r_hit;
    logic [IDX_W-1:0]             w_idx, r_idx;
    logic [IDX_W-1:0]             head, tail;
    logic [OCC_W-1:0]             count;
    wr_disp_e                     disp;
    logic                         merge_en, alloc_en, issue, full, empty, head_merge;

    wpq_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wcam (
        .valid_vec(valid_vec), .addr_vec(addr_vec), .key(wr_addr),
        .match(w_match), .hit(w_hit), .idx(w_idx));

    wpq_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rcam (
        .valid_vec(valid_vec), .addr_vec(addr_vec), .key(rd_addr),
        .match(r_match), .hit(r_hit), .idx(r_idx));

    wpq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BYTES(BYTES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_idx(tail),
        .merge_en(merge_en), .merge_idx(w_idx),
        .free_en(issue), .free_idx(head),
        .in_addr(wr_addr), .in_data(wr_data), .in_be(wr_be),
        .valid_vec(valid_vec), .addr_vec(addr_vec), .data_vec(data_vec), .be_vec(be_vec));

    // Classify the incoming write and decide whether the head slot may go out.
    always_comb begin
        disp       = !wr_valid ? WD_NONE : (w_hit ? WD_MERGE : WD_ALLOC);
        merge_en   = (disp == WD_MERGE);
        alloc_en   = (disp == WD_ALLOC);
        full       = (count == OCC_W'(DEPTH));
        empty      = (count == '0);
        head_merge = merge_en && (w_idx == head);
        iss_valid  = !empty && !head_merge;
        issue      = iss_valid && iss_ready;
        iss_addr   = addr_vec[head];
        iss_data   = data_vec[head];
        iss_be     = be_vec[head];
        occupancy  = count;
    end

    // Ring pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= head + IDX_W'(issue);
            tail  <= tail + IDX_W'(alloc_en);
            count <= count + OCC_W'(alloc_en) - OCC_W'(issue);
        end
    end

    // Registered responses: posted acknowledge, credits, read forwarding, monitor pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_posted     <= 1'b0;
            posted_cnt    <= '0;
            credit_ret    <= '0;
            rd_resp_valid <= 1'b0;
            rd_resp_hit   <= 1'b0;
            rd_resp_data  <= '0;
            rd_hit_pulse  <= 1'b0;
            wr_hit_pulse  <= 1'b0;
        end else begin
            wr_posted     <= wr_valid;
            posted_cnt    <= posted_cnt + CNT_W'(wr_valid);
            credit_ret    <= 2'(issue) + 2'(merge_en);
            rd_resp_valid <= rd_valid;
            rd_resp_hit   <= rd_valid && r_hit;
            rd_resp_data  <= (rd_valid && r_hit) ? data_vec[r_idx] : '0;
            rd_hit_pulse  <= rd_valid && r_hit;
            wr_hit_pulse  <= merge_en;
        end
    end

    // Guards
    a_r3_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full);
    a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= OCC_W'(DEPTH));
    a_r12_unique_wr_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(w_match));
    a_r12_unique_rd_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_match));
    a_r7_head_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |-> valid_vec[head]);
    a_r7_freed_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !(alloc_en && tail == head)) |=> !valid_vec[$past(head)]);
    a_r2_posted: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> wr_posted);
    a_r3_count_matches_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_vec) == int'(count));
    a_r6_hit_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_resp_hit |-> rd_resp_valid);
endmodule

// File: tb/sim_wpq_top.sv
// Bench for wpq_top: directed phases followed by a random mix.
// Each cycle is compared against a queue-based model kept in the bench.
module sim_wpq_top;
    localparam int DEPTH = 32;
    localparam int AW    = 16;
    localparam int NB    = 8;
    localparam int DW    = 8 * NB;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [NB-1:0] be;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, rd_valid = 1'b0, iss_ready = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NB-1:0] wr_be = '0;
    logic wr_posted, rd_resp_valid, rd_resp_hit, iss_valid, rd_hit_pulse, wr_hit_pulse;
    logic [1:0] credit_ret;
    logic [DW-1:0] rd_resp_data, iss_data;
    logic [AW-1:0] iss_addr;
    logic [NB-1:0] iss_be;
    logic [5:0] occupancy;
    logic [15:0] posted_cnt;

    always #4 clk = ~clk;

    wpq_top u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_posted(wr_posted), .credit_ret(credit_ret),
        .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_hit(rd_resp_hit), .rd_resp_data(rd_resp_data),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_addr(iss_addr), .iss_data(iss_data), .iss_be(iss_be),
        .occupancy(occupancy), .posted_cnt(posted_cnt),
        .rd_hit_pulse(rd_hit_pulse), .wr_hit_pulse(wr_hit_pulse));

    ent_t q[$];
    int n_chk = 0, n_bad = 0;
    int creds = DEPTH;
    int pc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int find(input logic [AW-1:0] a);
        for (int i = 0; i < q.size(); i++) if (q[i].a == a) return i;
        return -1;
    endfunction

    // One cycle: drive inputs, check issue port, advance model, check registered outputs.
    task automatic step(input bit wv, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic [NB-1:0] wbe, input bit rv, input logic [AW-1:0] ra,
                        input bit rdy);
        int wi, ri, e_cred;
        bit e_iss, e_rhit;
        logic [DW-1:0] e_rdata;
        if (wv && creds == 0) wv = 0;
        wr_valid = wv; wr_addr = wa; wr_data = wd; wr_be = wbe;
        rd_valid = rv; rd_addr = ra; iss_ready = rdy;
        #1;
        wi = wv ? find(wa) : -1;
        ri = rv ? find(ra) : -1;
        e_iss = (q.size() > 0) && !(wi == 0);
        chk(iss_valid == e_iss, "R7 R8 iss_valid", DW'(iss_valid), DW'(e_iss));
        if (e_iss) begin
            chk(iss_addr == q[0].a, "R7 iss_addr", DW'(iss_addr), DW'(q[0].a));
            chk(iss_data == q[0].d && iss_be == q[0].be, "R7 iss_data", iss_data, q[0].d);
        end
        e_rhit  = (ri >= 0);
        e_rdata = e_rhit ? q[ri].d : '0;
        e_cred  = ((e_iss && rdy) ? 1 : 0) + ((wi >= 0) ? 1 : 0);
        if (wv) begin
            creds--; pc++;
            if (wi >= 0) begin
                for (int b = 0; b < NB; b++) if (wbe[b]) q[wi].d[8*b +: 8] = wd[8*b +: 8];
                q[wi].be = q[wi].be | wbe;
            end else begin
                ent_t e;
                e.a = wa; e.be = wbe; e.d = '0;
                for (int b = 0; b < NB; b++) if (wbe[b]) e.d[8*b +: 8] = wd[8*b +: 8];
                q.push_back(e);
            end
        end
        if (e_iss && rdy) void'(q.pop_front());
        @(posedge clk); #2;
        chk(wr_posted == wv, "R2 wr_posted", DW'(wr_posted), DW'(wv));
        chk(posted_cnt == 16'(pc), "R2 posted_cnt", DW'(posted_cnt), DW'(16'(pc)));
        chk(int'(credit_ret) == e_cred, "R9 credit_ret", DW'(credit_ret), DW'(e_cred));
        chk(int'(occupancy) == q.size(), "R3 occupancy", DW'(occupancy), DW'(q.size()));
        chk(rd_resp_valid == rv && rd_resp_hit == e_rhit, "R6 rd_resp_hit", DW'(rd_resp_hit), DW'(e_rhit));
        chk(rd_resp_data == e_rdata, "R6 R11 rd_resp_data", rd_resp_data, e_rdata);
        chk(rd_hit_pulse == e_rhit && wr_hit_pulse == (wi >= 0), "R10 hit pulses",
            DW'({rd_hit_pulse, wr_hit_pulse}), DW'({e_rhit, wi >= 0}));
        creds += e_cred;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        // R1: reset state
        chk(occupancy == 0 && !iss_valid, "R1 empty after reset", DW'(occupancy), 0);
        chk(!wr_posted && credit_ret == 0 && !rd_resp_valid && posted_cnt == 0
            && !rd_hit_pulse && !wr_hit_pulse, "R1 outputs idle", DW'(posted_cnt), 0);
        rst_n = 1'b1;

        // R3: fill 30 distinct addresses with the issue port stalled
        for (int i = 0; i < 30; i++)
            step(1, AW'(16'h100 + i), {8{8'(i)}}, 8'hFF, 0, '0, 0);

        // R4: full write merge, then read it back
        step(1, 16'h105, {16{4'hA}}, 8'hFF, 0, '0, 0);
        step(0, '0, '0, '0, 1, 16'h105, 0);
        chk(rd_resp_data == {16{4'hA}}, "R4 full replace", rd_resp_data, {16{4'hA}});
        chk(occupancy == 30, "R4 no new slot", DW'(occupancy), 30);

        // R5: partial merge on lanes 0..3
        step(1, 16'h106, {DW{1'b1}}, 8'h0F, 0, '0, 0);
        step(0, '0, '0, '0, 1, 16'h106, 0);
        chk(rd_resp_data == 64'h06060606FFFFFFFF, "R5 lane merge", rd_resp_data, 64'h06060606FFFFFFFF);

        // R11: read and write to the same address in one cycle
        step(1, 16'h107, {8{8'h77}}, 8'hFF, 1, 16'h107, 0);
        chk(rd_resp_data == {8{8'h07}}, "R11 read sees prior state", rd_resp_data, {8{8'h07}});

        // R6: read miss
        step(0, '0, '0, '0, 1, 16'h999, 0);
        chk(!rd_resp_hit && rd_resp_data == 0, "R6 miss", rd_resp_data, 0);

        // R8: write to the oldest slot while the DRAM side is ready
        wr_valid = 1; wr_addr = 16'h100; wr_data = '0; wr_be = 8'h01; iss_ready = 1;
        #1;
        chk(!iss_valid, "R8 issue held on head merge", DW'(iss_valid), 0);
        step(1, 16'h100, '0, 8'h01, 0, '0, 1);

        // R3: fill the last two slots
        step(1, 16'h200, {8{8'h20}}, 8'hFF, 0, '0, 0);
        step(1, 16'h201, {8{8'h21}}, 8'hF0, 0, '0, 0);
        chk(occupancy == 32 && creds == 0, "R3 full at depth", DW'(occupancy), 32);

        // R7 R9: drain in age order
        for (int i = 0; i < 34; i++) step(0, '0, '0, '0, 0, '0, 1);
        chk(occupancy == 0 && creds == DEPTH, "R9 all credits back", DW'(creds), DW'(DEPTH));

        // Random mix over a small address set
        for (int i = 0; i < 4000; i++)
            step(bit'($urandom_range(0, 1)), AW'($urandom_range(0, 7)), {$urandom, $urandom},
                 NB'($urandom), bit'($urandom_range(0, 1)), AW'($urandom_range(0, 7)),
                 bit'($urandom_range(0, 2) == 0));
        for (int i = 0; i < 40; i++) step(0, '0, '0, '0, 0, '0, 1);
        chk(creds == DEPTH, "R9 credits balanced", DW'(creds), DW'(DEPTH));

        done = 1;
        finish_run();
    end
endmodule